// File: doc/BRIEF.md
# Command Thread Executor

This block is one hardware command thread. Software places a list of 64-bit instructions in memory, programs a start address and a stop address, and enables the thread. The thread then fetches one instruction at a time, and for each one it issues a register write to a target subsystem, loads a write mask, jumps, waits on or updates an external event flag, or marks the end of a command batch with a done interrupt. It lets register updates with tight timing, such as display reconfiguration inside a blanking interval, happen without processor involvement.

Software controls the thread through a small register slave. The slave offers a self-clearing warm reset, an enable, and a suspend request that is acknowledged in a status bit. It also has interrupt status and enable registers, and a wait indicator for event stalls. A write to the current-address register, even one that rewrites its present value, drops the instruction in flight and makes the thread fetch again from that address. Software uses this to splice new command buffers into a running stream.

Top module: `cmd_thread`

## Requirements
- R1: After reset the thread is disabled and `irq`, `fetch_req`, `tgt_we` and `ev_req` are low. The current-address, end-address, status and interrupt-status registers all read 0.
- R2: While enabled and not suspended, the thread fetches from the current address and advances it by 8 after each instruction that does not jump. It keeps at most one fetch outstanding and issues no fetch while the current address equals the end address.
- R3: Opcode 0x04, in bits 63:56, issues one target write carrying the lower word as data. Bits 55:48 hold the subsystem id, and ids 1, 2 and 3 give address bits 31:16 of 0x1400, 0x1401 and 0x1402. Bits 47:33 give address bits 15:1, and address bit 0 is 0.
- R4: Opcode 0x02 loads its lower word as a preserve mask, in which a set bit keeps that target bit. A write with bit 32 set presents the last loaded mask on `tgt_keep`, and a write with bit 32 clear presents 0.
- R5: Opcode 0x10 takes bits 55:32 as a mode. Mode 0 jumps to the jump instruction's own address plus the lower word, so an offset of 8 steps to the next instruction. Mode 1 jumps to the lower word as an absolute address.
- R6: Opcode 0x20 drives `ev_id` from bits 41:32, `ev_wait` from bit 15 and `ev_set` from bit 31. It holds `ev_req` high until `ev_ack`. Bit 31 of the wait-token register (0x30) reads 1 while the thread waits with `ev_wait` set.
- R7: Opcode 0x40 with lower-word bit 0 set sets interrupt-status bit 0. With that bit clear it leaves the interrupt status unchanged.
- R8: An undefined opcode, or a jump mode above 1, sets interrupt-status bit 1. A write to a subsystem id outside 1..3 sets bit 4. In either case the thread issues no target write, halts with status bit 0 set, and fetches nothing more until a warm reset or disable.
- R9: Writing the interrupt-status register (0x10) clears the bits written as 0 and keeps the bits written as 1. `irq` is high one cycle after any bit is set in both interrupt status and interrupt enable (0x14).
- R10: Setting suspend (0x08 bit 0) stops the thread at an instruction boundary. A pending event request is withdrawn, and status bit 1 (0x0C) rises within a bounded number of cycles. While suspended the thread makes no target writes. Clearing suspend resumes execution from the current address.
- R11: Writing the current address (0x20) cancels the instruction being fetched, executed or waited on, and fetching restarts from the written value, even when that value is unchanged.
- R12: Writing 1 to warm-reset bit 0 (0x00) self-clears after one cycle. It clears enable, suspend, interrupt status, the preserve mask and the halt, and it keeps the current and end addresses.
- R13: Register reads return data on `csr_rdata` in the cycle after `csr_re`. Enable is bit 0 of 0x04 and the end address is 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after `csr_re` |
| fetch_req | output | 1 | Instruction fetch request pulse |
| fetch_addr | output | AW | Instruction fetch byte address |
| fetch_valid | input | 1 | Fetched instruction valid |
| fetch_data | input | 64 | Fetched instruction |
| tgt_we | output | 1 | Target register write pulse |
| tgt_addr | output | 32 | Target register address |
| tgt_data | output | 32 | Target write data |
| tgt_keep | output | 32 | Target bits to preserve |
| ev_req | output | 1 | Event operation request |
| ev_id | output | EW | Event number |
| ev_wait | output | 1 | Wait for the event flag |
| ev_set | output | 1 | Update the event flag |
| ev_ack | input | 1 | Event operation complete |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after the bit 32 selection of the write mask. A design that latched the mask wrongly would preserve bits on plain writes or would overwrite bits that should be kept. It also drives jumps of relative offset 8 and 16 and an absolute jump, where an off-by-one base would execute skipped writes. It rewrites the current address with its own value during an event stall, and a design that ignored this no-change write would never raise its event request a second time. Finally it suspends during an event wait and then checks the status acknowledge and the interrupt-status write-zero-to-clear rule. A wrong design would either keep the request asserted or clear the done bit when 1 is written to it.

// File: rtl/cmd_thread_pkg.sv
package cmd_thread_pkg;
  localparam logic [7:0] OPC_MASK  = 8'h02;
  localparam logic [7:0] OPC_WRITE = 8'h04;
  localparam logic [7:0] OPC_JUMP  = 8'h10;
  localparam logic [7:0] OPC_EVENT = 8'h20;
  localparam logic [7:0] OPC_EOC   = 8'h40;

  localparam logic [7:0] CSR_WRST  = 8'h00;
  localparam logic [7:0] CSR_EN    = 8'h04;
  localparam logic [7:0] CSR_SUSP  = 8'h08;
  localparam logic [7:0] CSR_STAT  = 8'h0C;
  localparam logic [7:0] CSR_IST   = 8'h10;
  localparam logic [7:0] CSR_IEN   = 8'h14;
  localparam logic [7:0] CSR_CUR   = 8'h20;
  localparam logic [7:0] CSR_END   = 8'h24;
  localparam logic [7:0] CSR_TOKEN = 8'h30;

  localparam logic [31:0] IST_LIVE = 32'h0000_0013;

  typedef enum logic [2:0] {TS_READY, TS_FETCH_WAIT, TS_EXEC, TS_EVENT, TS_HALT} tstate_e;

  typedef struct packed {
    logic [7:0]  opc;
    logic [23:0] arg;
    logic [31:0] val;
  } instr_t;
endpackage

// File: rtl/cmd_subsys_map.sv
module cmd_subsys_map #(
  parameter int          NSUB = 3,
  parameter logic [15:0] BASE = 16'h1400
) (
  input  logic [7:0]  id,
  output logic        hit,
  output logic [15:0] hi
);
  logic [NSUB-1:0] match;
  logic [15:0]     part [NSUB];

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign match[g] = (id == 8'(g + 1));
    assign part[g]  = match[g] ? (BASE + 16'(g)) : 16'h0;
  end

  always_comb begin
    hi = '0;
    for (int i = 0; i < NSUB; i++) hi = hi | part[i];
  end

  assign hit = |match;
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_thread_pkg::*;
#(
  parameter int          NSUB     = 3,
  parameter logic [15:0] SUB_BASE = 16'h1400
) (
  input  instr_t      ir,
  output logic        is_mask,
  output logic        is_write,
  output logic        is_jump,
  output logic        is_event,
  output logic        is_eoc,
  output logic        bad_op,
  output logic        bad_addr,
  output logic        jump_abs,
  output logic        keep_sel,
  output logic [31:0] tgt_addr
);
  logic        sub_hit;
  logic [15:0] sub_hi;

  cmd_subsys_map #(.NSUB(NSUB), .BASE(SUB_BASE)) u_map (
    .id (ir.arg[23:16]),
    .hit(sub_hit),
    .hi (sub_hi)
  );

  assign is_mask  = (ir.opc == OPC_MASK);
  assign is_write = (ir.opc == OPC_WRITE);
  assign is_jump  = (ir.opc == OPC_JUMP);
  assign is_event = (ir.opc == OPC_EVENT);
  assign is_eoc   = (ir.opc == OPC_EOC);
  assign jump_abs = (ir.arg == 24'd1);
  assign bad_op   = !(is_mask | is_write | is_jump | is_event | is_eoc)
                  || (is_jump && (ir.arg > 24'd1));
  assign bad_addr = is_write && !sub_hit;
  assign keep_sel = ir.arg[0];
  assign tgt_addr = {sub_hi, ir.arg[15:1], 1'b0};
endmodule

// File: rtl/cmd_irq.sv
module cmd_irq
  import cmd_thread_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_all,
  input  logic        wr_ist,
  input  logic        wr_ien,
  input  logic [31:0] wdata,
  input  logic        set_done,
  input  logic        set_op_err,
  input  logic        set_addr_err,
  output logic [31:0] ist,
  output logic [31:0] ien,
  output logic        irq
);
  logic [31:0] ist_n;

  always_comb begin
    ist_n = ist;
    if (wr_ist) ist_n = ist_n & wdata;
    ist_n[0] = ist_n[0] | set_done;
    ist_n[1] = ist_n[1] | set_op_err;
    ist_n[4] = ist_n[4] | set_addr_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ist <= '0;
      ien <= '0;
      irq <= 1'b0;
    end else begin
      ist <= clr_all ? '0 : (ist_n & IST_LIVE);
      if (wr_ien) ien <= wdata & IST_LIVE;
      irq <= |(ist & ien);
    end
  end
endmodule

// File: rtl/cmd_thread.sv
module cmd_thread
  import cmd_thread_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          EW       = 10,
  parameter int          NSUB     = 3,
  parameter logic [15:0] SUB_BASE = 16'h1400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csr_we,
  input  logic          csr_re,
  input  logic [7:0]    csr_addr,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_valid,
  input  logic [63:0]   fetch_data,
  output logic          tgt_we,
  output logic [31:0]   tgt_addr,
  output logic [31:0]   tgt_data,
  output logic [31:0]   tgt_keep,
  output logic          ev_req,
  output logic [EW-1:0] ev_id,
  output logic          ev_wait,
  output logic          ev_set,
  input  logic          ev_ack,
  output logic          irq
);
  localparam logic [AW-1:0] STEP = AW'(8);

  tstate_e       st;
  instr_t        ir;
  logic [AW-1:0] cur, endp;
  logic          enable, susp, wrst_q, outst;
  logic [31:0]   mask_q;
  logic [31:0]   ist, ien;

  logic is_mask, is_write, is_jump, is_event, is_eoc;
  logic bad_op, bad_addr, jump_abs, keep_sel;
  logic [31:0] dec_addr;

  cmd_decode #(.NSUB(NSUB), .SUB_BASE(SUB_BASE)) u_dec (
    .ir(ir), .is_mask(is_mask), .is_write(is_write), .is_jump(is_jump),
    .is_event(is_event), .is_eoc(is_eoc), .bad_op(bad_op), .bad_addr(bad_addr),
    .jump_abs(jump_abs), .keep_sel(keep_sel), .tgt_addr(dec_addr)
  );

  logic kill, wr_cur, exec_ok, is_halted, is_susp_ack, can_fetch;
  logic set_done, set_op_err, set_addr_err;
  logic [AW-1:0] jump_tgt;

  assign kill         = wrst_q || !enable;
  assign wr_cur       = csr_we && (csr_addr == CSR_CUR);
  assign exec_ok      = (st == TS_EXEC) && !kill && !wr_cur;
  assign is_halted    = (st == TS_HALT);
  assign is_susp_ack  = susp && ((st == TS_READY) || is_halted);
  assign can_fetch    = enable && !susp && !outst && !wrst_q && !wr_cur && (cur != endp);
  assign set_done     = exec_ok && is_eoc && ir.val[0];
  assign set_op_err   = exec_ok && bad_op;
  assign set_addr_err = exec_ok && !bad_op && bad_addr;
  assign jump_tgt     = jump_abs ? ir.val[AW-1:0] : (cur + ir.val[AW-1:0]);

  assign ev_req  = (st == TS_EVENT);
  assign ev_id   = ir.arg[EW-1:0];
  assign ev_wait = ir.val[15];
  assign ev_set  = ir.val[31];

  cmd_irq u_irq (
    .clk(clk), .rst(rst), .clr_all(wrst_q),
    .wr_ist(csr_we && (csr_addr == CSR_IST)),
    .wr_ien(csr_we && (csr_addr == CSR_IEN)),
    .wdata(csr_wdata), .set_done(set_done), .set_op_err(set_op_err),
    .set_addr_err(set_addr_err), .ist(ist), .ien(ien), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TS_READY;        ir <= '0;
      cur <= '0;             endp <= '0;
      enable <= 1'b0;        susp <= 1'b0;
      wrst_q <= 1'b0;        outst <= 1'b0;
      mask_q <= '0;          fetch_req <= 1'b0;
      fetch_addr <= '0;      tgt_we <= 1'b0;
      tgt_addr <= '0;        tgt_data <= '0;
      tgt_keep <= '0;        csr_rdata <= '0;
    end else begin
      fetch_req <= 1'b0;
      tgt_we    <= 1'b0;
      if (fetch_valid) outst <= 1'b0;

      if (kill || (wr_cur && st != TS_HALT)) begin
        st <= TS_READY;
      end else begin
        unique case (st)
          TS_READY: if (can_fetch) begin
            fetch_req  <= 1'b1;
            fetch_addr <= cur;
            outst      <= 1'b1;
            st         <= TS_FETCH_WAIT;
          end
          TS_FETCH_WAIT: if (fetch_valid) begin
            ir <= fetch_data;
            st <= susp ? TS_READY : TS_EXEC;
          end
          TS_EXEC: begin
            if (bad_op || bad_addr) st <= TS_HALT;
            else if (is_event)      st <= TS_EVENT;
            else begin
              st  <= TS_READY;
              cur <= is_jump ? jump_tgt : (cur + STEP);
            end
            if (is_mask) mask_q <= ir.val;
            if (is_write && !bad_addr) begin
              tgt_we   <= 1'b1;
              tgt_addr <= dec_addr;
              tgt_data <= ir.val;
              tgt_keep <= keep_sel ? mask_q : 32'h0;
            end
          end
          TS_EVENT: begin
            if (ev_ack) begin
              cur <= cur + STEP;
              st  <= TS_READY;
            end else if (susp) begin
              st <= TS_READY;
            end
          end
          default: ;
        endcase
      end

      wrst_q <= csr_we && (csr_addr == CSR_WRST) && csr_wdata[0];
      if (csr_we) begin
        if (csr_addr == CSR_EN)   enable <= csr_wdata[0];
        if (csr_addr == CSR_SUSP) susp   <= csr_wdata[0];
        if (csr_addr == CSR_CUR)  cur    <= csr_wdata[AW-1:0];
        if (csr_addr == CSR_END)  endp   <= csr_wdata[AW-1:0];
      end
      if (wrst_q) begin
        enable <= 1'b0;
        susp   <= 1'b0;
        mask_q <= '0;
      end

      if (csr_re) begin
        unique case (csr_addr)
          CSR_WRST:  csr_rdata <= {31'h0, wrst_q};
          CSR_EN:    csr_rdata <= {31'h0, enable};
          CSR_SUSP:  csr_rdata <= {31'h0, susp};
          CSR_STAT:  csr_rdata <= {30'h0, is_susp_ack, is_halted};
          CSR_IST:   csr_rdata <= ist;
          CSR_IEN:   csr_rdata <= ien;
          CSR_CUR:   csr_rdata <= 32'(cur);
          CSR_END:   csr_rdata <= 32'(endp);
          CSR_TOKEN: csr_rdata <= {(st == TS_EVENT) && ev_wait, 31'h0};
          default:   csr_rdata <= 32'h0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_thread_chk.sv
module cmd_thread_chk #(
  parameter int AW         = 32,
  parameter int SUSP_LIMIT = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_req,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_addr,
  input logic [AW-1:0] cur,
  input logic [AW-1:0] endp,
  input logic          tgt_we,
  input logic          halted,
  input logic          enable,
  input logic          susp,
  input logic          susp_ack,
  input logic          wrst_q,
  input logic          csr_we,
  input logic [7:0]    csr_addr,
  input logic [31:0]   csr_wdata,
  input logic          set_done,
  input logic [31:0]   ist
);
  logic pend;
  int   susp_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      susp_wait <= 0;
    end else begin
      if (fetch_req)        pend <= 1'b1;
      else if (fetch_valid) pend <= 1'b0;
      susp_wait <= (enable && susp && !susp_ack) ? susp_wait + 1 : 0;
    end
  end

  assert_one_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> !pend);

  assert_stop_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> ($past(cur != endp) && fetch_addr == $past(cur)));

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (halted && $past(halted)) |-> (!tgt_we && !fetch_req));

  assert_wrst_selfclear_R12: assert property (@(posedge clk) disable iff (rst)
    (wrst_q && !(csr_we && csr_addr == 8'h00 && csr_wdata[0])) |=> !wrst_q);

  assert_susp_bound_R10: assert property (@(posedge clk) disable iff (rst)
    susp_wait < SUSP_LIMIT);

  assert_susp_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (susp_ack && $past(susp_ack)) |-> !tgt_we);

  assert_ist_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_addr == 8'h10 && !csr_wdata[0] && !set_done) |=> !ist[0]);
endmodule

bind cmd_thread cmd_thread_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
  .fetch_addr(fetch_addr), .cur(cur), .endp(endp), .tgt_we(tgt_we),
  .halted(is_halted), .enable(enable), .susp(susp), .susp_ack(is_susp_ack),
  .wrst_q(wrst_q), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
  .set_done(set_done), .ist(ist)
);

// File: tb/cmd_thread_tb.sv
module cmd_thread_tb;
  import cmd_thread_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        csr_we = 0, csr_re = 0;
  logic [7:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        fetch_req, fetch_valid = 0;
  logic [31:0] fetch_addr;
  logic [63:0] fetch_data = 0;
  logic        tgt_we;
  logic [31:0] tgt_addr, tgt_data, tgt_keep;
  logic        ev_req, ev_wait, ev_set, ev_ack = 0;
  logic [9:0]  ev_id;
  logic        irq;

  cmd_thread u_dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_keep(tgt_keep),
    .ev_req(ev_req), .ev_id(ev_id), .ev_wait(ev_wait), .ev_set(ev_set),
    .ev_ack(ev_ack), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  logic [63:0] mem [0:255];
  int fetch_count = 0, ev_rise = 0, n_log = 0;
  logic [31:0] lg_a [0:63], lg_d [0:63], lg_k [0:63];
  logic m_pend = 0, ev_auto = 0, ev_prev = 0;
  logic [31:0] m_addr = 0;
  int m_cnt = 0;

  // memory model: one outstanding request, 1 to 3 cycles latency
  always @(negedge clk) begin
    fetch_valid = 1'b0;
    if (m_pend) begin
      if (m_cnt == 0) begin
        fetch_valid = 1'b1;
        fetch_data  = mem[m_addr[10:3]];
        m_pend      = 1'b0;
      end else m_cnt--;
    end
    if (fetch_req) begin
      m_pend = 1'b1;
      m_addr = fetch_addr;
      m_cnt  = $urandom_range(0, 2);
      fetch_count++;
    end
    if (tgt_we && n_log < 64) begin
      lg_a[n_log] = tgt_addr; lg_d[n_log] = tgt_data; lg_k[n_log] = tgt_keep;
      n_log++;
    end
    if (ev_req && !ev_prev) ev_rise++;
    ev_prev = ev_req;
    ev_ack  = ev_auto && ev_req && !ev_ack;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic csr_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); csr_re = 1; csr_addr = a;
    @(negedge clk); csr_re = 0; d = csr_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] i_wr(input logic [7:0] sub, input logic [15:0] off, input logic [31:0] d);
    return {OPC_WRITE, sub, off, d};
  endfunction
  function automatic logic [63:0] i_mask(input logic [31:0] keep);
    return {OPC_MASK, 24'h0, keep};
  endfunction
  function automatic logic [63:0] i_jmp(input logic [23:0] mode, input logic [31:0] v);
    return {OPC_JUMP, mode, v};
  endfunction
  function automatic logic [63:0] i_ev(input logic [9:0] id, input logic w, input logic s);
    return {OPC_EVENT, 14'h0, id, s, 15'h0, w, 15'h0};
  endfunction
  function automatic logic [63:0] i_eoc(input logic b);
    return {OPC_EOC, 24'h0, 31'h0, b};
  endfunction
  function automatic logic [31:0] exp_addr(input logic [7:0] sub, input logic [15:0] off);
    return {16'h1400 + 16'(sub) - 16'h1, off & 16'hFFFE};
  endfunction

  task automatic start(input logic [31:0] s, input logic [31:0] e);
    csr_wr(CSR_WRST, 32'h1);
    csr_wr(CSR_IEN, 32'h13);
    csr_wr(CSR_CUR, s);
    csr_wr(CSR_END, e);
    n_log = 0;
    csr_wr(CSR_EN, 32'h1);
  endtask

  logic [31:0] r;
  int fc;

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 64'h0;
    settle(3);
    rst = 0;
    settle(2);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 fetch_req", fetch_req, 0);
    csr_rd(CSR_CUR, r);  chk("R1 cur", r, 0);
    csr_rd(CSR_STAT, r); chk("R1 status", r, 0);
    csr_rd(CSR_IST, r);  chk("R1 ist", r, 0);

    // R3 R7 R2 basic writes
    mem[8'h20] = i_wr(1, 16'h0010, 32'hA5A5A5A5);
    mem[8'h21] = i_wr(3, 16'h0204, 32'h12345678);
    mem[8'h22] = i_wr(2, 16'hFFFE, 32'h0F0F0F0F);
    mem[8'h23] = i_eoc(1);
    start(32'h100, 32'h120);
    settle(60);
    chk("R3 count", n_log, 3);
    chk("R3 addr0", lg_a[0], 32'h14000010);
    chk("R3 data0", lg_d[0], 32'hA5A5A5A5);
    chk("R3 addr1", lg_a[1], 32'h14020204);
    chk("R3 addr2", lg_a[2], 32'h1401FFFE);
    chk("R4 keep plain", lg_k[2], 0);
    chk("R7 irq", irq, 1);
    csr_rd(CSR_CUR, r);  chk("R2 cur at end", r, 32'h120);
    fc = fetch_count; settle(20);
    chk("R2 no fetch at end", fetch_count, fc);
    // R9 write 0 clears, write 1 keeps
    csr_wr(CSR_IST, 32'h12);
    csr_rd(CSR_IST, r);  chk("R9 clear by zero", r, 0);
    chk("R9 irq low", irq, 0);
    csr_wr(CSR_CUR, 32'h100); settle(60);
    csr_wr(CSR_IST, 32'h1);
    csr_rd(CSR_IST, r);  chk("R9 one keeps", r, 1);

    // R4 mask, R7 eoc without bit
    mem[8'h30] = i_mask(32'hFFFF0000);
    mem[8'h31] = i_wr(2, 16'h0031, 32'hAAAA5555);
    mem[8'h32] = i_wr(2, 16'h0030, 32'h11112222);
    mem[8'h33] = i_eoc(0);
    start(32'h180, 32'h1A0);
    settle(60);
    chk("R4 count", n_log, 2);
    chk("R4 addr", lg_a[0], 32'h14010030);
    chk("R4 keep", lg_k[0], 32'hFFFF0000);
    chk("R4 keep off", lg_k[1], 0);
    csr_rd(CSR_IST, r);  chk("R7 no done", r, 0);

    // R5 jumps
    mem[8'h40] = i_jmp(0, 32'd16);
    mem[8'h41] = i_wr(2, 16'hBAD0, 32'hDEAD);
    mem[8'h42] = i_jmp(0, 32'd8);
    mem[8'h43] = i_wr(1, 16'h0100, 32'h1111);
    mem[8'h44] = i_jmp(1, 32'h280);
    mem[8'h45] = i_wr(2, 16'hBAD2, 32'hDEAD);
    mem[8'h50] = i_wr(3, 16'h0300, 32'h3333);
    mem[8'h51] = i_eoc(1);
    start(32'h200, 32'h290);
    settle(80);
    chk("R5 count", n_log, 2);
    chk("R5 rel", lg_a[0], 32'h14000100);
    chk("R5 abs", lg_a[1], 32'h14020300);
    chk("R5 data", lg_d[1], 32'h3333);

    // R6 R11 event stall and current address rewrite
    mem[8'h60] = i_ev(10'd5, 1, 1);
    mem[8'h61] = i_eoc(1);
    mem[8'h62] = i_jmp(1, 32'h3F8);
    mem[8'h70] = i_wr(1, 16'h0444, 32'h4444);
    mem[8'h71] = i_eoc(1);
    mem[8'h72] = i_jmp(1, 32'h3F8);
    ev_auto = 0; ev_rise = 0;
    start(32'h300, 32'h3F8);
    settle(20);
    chk("R6 ev_req", ev_req, 1);
    chk("R6 ev_id", ev_id, 5);
    chk("R6 wait/set", {ev_wait, ev_set}, 2'b11);
    csr_rd(CSR_TOKEN, r); chk("R6 token", r[31], 1);
    chk("R6 held no write", n_log, 0);
    csr_wr(CSR_CUR, 32'h300); settle(20);
    chk("R11 same value refetch", ev_rise, 2);
    csr_wr(CSR_CUR, 32'h380); settle(40);
    chk("R11 new stream", n_log, 1);
    chk("R11 new addr", lg_a[0], 32'h14000444);
    chk("R11 ev dropped", ev_req, 0);

    // R10 suspend during event wait
    mem[8'h80] = i_ev(10'd7, 1, 0);
    mem[8'h81] = i_wr(1, 16'h0040, 32'h77);
    mem[8'h82] = i_eoc(1);
    start(32'h400, 32'h418);
    settle(20);
    csr_wr(CSR_SUSP, 32'h1); settle(5);
    csr_rd(CSR_STAT, r);  chk("R10 ack", r[1], 1);
    chk("R10 ev withdrawn", ev_req, 0);
    ev_auto = 1; settle(30);
    chk("R10 no write suspended", n_log, 0);
    csr_rd(CSR_CUR, r);   chk("R10 cur held", r, 32'h400);
    csr_wr(CSR_SUSP, 32'h0); settle(40);
    chk("R10 resumed", n_log, 1);
    chk("R10 resumed addr", lg_a[0], 32'h14000040);
    csr_rd(CSR_IST, r);   chk("R10 done", r, 1);

    // R8 undefined opcode
    mem[8'hC0] = i_wr(1, 16'h0010, 32'h1);
    mem[8'hC1] = {8'h33, 56'h0};
    mem[8'hC2] = i_wr(1, 16'h0020, 32'h2);
    start(32'h600, 32'h618);
    settle(40);
    chk("R8 writes", n_log, 1);
    csr_rd(CSR_IST, r);   chk("R8 op err", r, 32'h2);
    chk("R8 irq", irq, 1);
    csr_rd(CSR_STAT, r);  chk("R8 halted", r[0], 1);
    fc = fetch_count; settle(20);
    chk("R8 no fetch", fetch_count, fc);
    // R12 warm reset
    csr_wr(CSR_WRST, 32'h1); settle(2);
    csr_rd(CSR_WRST, r);  chk("R12 selfclear", r, 0);
    csr_rd(CSR_EN, r);    chk("R12 enable off", r, 0);
    csr_rd(CSR_IST, r);   chk("R12 ist clear", r, 0);
    csr_rd(CSR_STAT, r);  chk("R12 halt clear", r, 0);
    csr_rd(CSR_END, r);   chk("R13 end kept", r, 32'h618);

    // R8 bad subsystem
    mem[8'hD0] = i_wr(4, 16'h0010, 32'h1);
    start(32'h680, 32'h688);
    settle(30);
    chk("R8 addr err none", n_log, 0);
    csr_rd(CSR_IST, r);   chk("R8 addr err", r, 32'h10);

    // R2 cur equals end
    fc = fetch_count;
    start(32'h700, 32'h700);
    settle(20);
    chk("R2 empty", fetch_count, fc);

    // R3 R4 random streams
    for (int it = 0; it < 20; it++) begin
      automatic int n = $urandom_range(1, 8);
      automatic int idx = 0;
      automatic logic [31:0] mk = 0;
      automatic logic [31:0] ea [0:7];
      automatic logic [31:0] ed [0:7];
      automatic logic [31:0] ek [0:7];
      for (int k = 0; k < n; k++) begin
        automatic logic [7:0]  sub = 8'($urandom_range(1, 3));
        automatic logic [15:0] off = 16'($urandom);
        automatic logic [31:0] d   = $urandom;
        if ($urandom_range(0, 2) == 0) begin
          mk = $urandom;
          mem[8'hA0 + 8'(idx)] = i_mask(mk); idx++;
        end
        mem[8'hA0 + 8'(idx)] = i_wr(sub, off, d); idx++;
        ea[k] = exp_addr(sub, off); ed[k] = d; ek[k] = off[0] ? mk : 32'h0;
      end
      mem[8'hA0 + 8'(idx)] = i_eoc(1); idx++;
      start(32'h500, 32'h500 + 32'(idx * 8));
      settle(100);
      chk("R3 rand count", n_log, n);
      for (int k = 0; k < n; k++) begin
        chk("R3 rand addr/data", {lg_a[k], lg_d[k]}, {ea[k], ed[k]});
        chk("R4 rand keep", lg_k[k], ek[k]);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule